// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches two external interrupt pins and turns activity on them into an interrupt request for a CPU core. Each pin has a 2-bit sense code that selects one of four modes: low level, any change, falling edge or rising edge. Each pin also has an enable bit and a pending flag. Every pin is brought into the clock domain by a synchroniser before any detection takes place. A detected edge sets the pin's pending flag. The flag stays set until software writes a one to it or until the CPU acknowledges entry into that pin's service routine. In low-level mode the flag is held at zero, and the request follows the synchronised pin level directly.

Software reaches three registers over a simple bus. The bus has an address, write data and a write strobe, and read data comes back combinationally. The request is gated by a global interrupt enable input and by each pin's enable bit. When both pins request at once, pin 0 wins, and a vector index output names the winner. Detection looks only at the pin level, so it works the same whether the pin is an input or is being driven as an output.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset all three registers read 0x00 and `irq_req` is low.
- R2: Register addresses are 0 for control, 1 for enable and 2 for flags. Address 3 reads zero. Control bits [1:0] hold pin 0's sense code and bits [3:2] hold pin 1's. Control bits [7:4] are plain read/write storage. In both the enable and flag registers, bit 6 is pin 0 and bit 7 is pin 1, and bits [5:0] read zero.
- R3: Sense code 11 selects rising edge. A low-to-high change sets the flag, and a high-to-low change does not.
- R4: Sense code 10 selects falling edge. A high-to-low change sets the flag, and a low-to-high change does not.
- R5: Sense code 01 selects any change. Both directions set the flag.
- R6: A set flag stays set in later cycles until something clears it.
- R7: Writing a one to a flag bit clears that flag. Writing a zero leaves it unchanged.
- R8: A one on `irq_ack[i]` clears pin i's flag.
- R9: Sense code 00 selects low level. The pin's flag reads zero, and the pin requests for as long as its synchronised level is low.
- R10: `irq_req` is high only when `gie` is high and the enable bit of a requesting pin is set.
- R11: When both pins request, `irq_vec` is 0. When only pin 1 requests, `irq_vec` is 1.
- R12: A pin change becomes visible in the flag after the third rising clock edge. A change becomes visible as a level request after the second. A pulse lasting one full clock period is always caught.
- R13: Changing the sense code while the pin is static does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 2 | Raw external interrupt pins |
| gie | input | 1 | Global interrupt enable from the CPU |
| irq_ack | input | 2 | Per-pin service acknowledge pulse |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 1 | Index of the winning pin |

## Verification
The bench checks the exact cycle at which a flag appears. A design that dropped a synchroniser stage, or that compared against a stale sample, would show the flag one cycle early or late. The bench also drives edges in the direction the mode must ignore, and it switches modes while the pin is static. A design that kept its history only in edge modes would raise a spurious flag in those cases. The bench checks that a written zero leaves a flag standing and that the flag is forced to zero in level mode; an inverted clear mask or a missing mode check would show up there. Finally, it raises both pins together and acknowledges them one at a time, which exposes a reversed priority or an acknowledge routed to the wrong pin.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    localparam int unsigned REG_W = 8;
    localparam int unsigned ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_ENA  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_FLAG = 2'd2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
    import ext_irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_raw,
    input  sense_e     sense,
    input  logic       clr,
    output logic       flag,
    output logic       level_req
);
    typedef struct packed {
        logic prev;
        logic flag;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     smp;
    logic     event_hit;

    ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_raw),
        .dout (smp)
    );

    always_comb begin
        st_d = st_q;
        // history tracks the pin in every mode, so a mode switch sees no stale edge
        st_d.prev = smp;
        unique case (sense)
            SENSE_ANY:  event_hit = smp ^ st_q.prev;
            SENSE_FALL: event_hit = st_q.prev & ~smp;
            SENSE_RISE: event_hit = ~st_q.prev & smp;
            default:    event_hit = 1'b0;
        endcase
        if (sense == SENSE_LOW) st_d.flag = 1'b0;
        else if (event_hit)     st_d.flag = 1'b1;
        else if (clr)           st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag      = st_q.flag;
    assign level_req = (sense == SENSE_LOW) & ~smp;

    a_r9_level_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sense == SENSE_LOW) |=> !flag);
    a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr && sense != SENSE_LOW) |=> flag);
    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && $stable(smp)) |=> !flag);
    a_r13_no_static_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && smp == st_q.prev) |=> !flag);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 2,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned VEC_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
    localparam int unsigned BIT_LSB    = REG_W - NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    input  logic                bus_we,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                gie,
    input  logic [NUM_PINS-1:0] irq_ack,
    output logic                irq_req,
    output logic [VEC_W-1:0]    irq_vec
);
    typedef struct packed {
        logic [REG_W-1:0]    ctrl;
        logic [NUM_PINS-1:0] ena;
    } regs_t;

    regs_t               r_d, r_q;
    logic [NUM_PINS-1:0] flag_w, lvl_w, clr_w, req_w;

    always_comb begin
        r_d = r_q;
        if (bus_we && bus_addr == ADR_CTRL) r_d.ctrl = bus_wdata;
        if (bus_we && bus_addr == ADR_ENA)  r_d.ena  = bus_wdata[REG_W-1:BIT_LSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign clr_w[i] = irq_ack[i] |
                          (bus_we && bus_addr == ADR_FLAG && bus_wdata[BIT_LSB+i]);

        ext_irq_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_raw  (pin_in[i]),
            .sense    (sense_e'(r_q.ctrl[2*i+1:2*i])),
            .clr      (clr_w[i]),
            .flag     (flag_w[i]),
            .level_req(lvl_w[i])
        );

        assign req_w[i] = gie & r_q.ena[i] & (flag_w[i] | lvl_w[i]);
    end

    always_comb begin
        irq_req = |req_w;
        irq_vec = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (req_w[i]) irq_vec = VEC_W'(i);
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CTRL: bus_rdata = r_q.ctrl;
            ADR_ENA:  bus_rdata[REG_W-1:BIT_LSB] = r_q.ena;
            ADR_FLAG: bus_rdata[REG_W-1:BIT_LSB] = flag_w;
            default:  bus_rdata = '0;
        endcase
    end

    a_r10_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (gie && (r_q.ena & (flag_w | lvl_w)) != '0));
    a_r11_pin0_wins: assert property (@(posedge clk) disable iff (!rst_n)
        req_w[0] |-> irq_vec == '0);
    a_r7_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_FLAG && !bus_wdata[BIT_LSB] && !irq_ack[0] && flag_w[0]
         && r_q.ctrl[1:0] != 2'b00) |=> flag_w[0]);
    a_r2_flag_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_FLAG) |-> bus_rdata[BIT_LSB-1:0] == '0);
endmodule

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic [1:0] pin_in = 2'b11;
    logic       gie = 1'b0;
    logic [1:0] irq_ack = '0;
    logic       irq_req;
    logic [0:0] irq_vec;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in), .gie(gie),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ack(input logic [1:0] m);
        irq_ack = m;
        @(negedge clk);
        irq_ack = '0;
    endtask

    task automatic settle_clear();
        tick(4);
        wr(2, 8'hC0);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(0, d); chk("R1 ctrl", d, 0);
        rd(1, d); chk("R1 ena", d, 0);
        rd(2, d); chk("R1 flag", d, 0);
        chk("R1 req", irq_req, 0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(0, 8'hA0); rd(0, d); chk("R2 ctrl storage", d, 8'hA0);
        wr(1, 8'hFF); rd(1, d); chk("R2 ena bits", d, 8'hC0);
        rd(3, d); chk("R2 addr3 zero", d, 0);
        wr(1, 8'h00); wr(0, 8'h00);
    endtask

    task automatic t_rise();
        logic [7:0] d;
        wr(0, 8'h03); pin_in[0] = 1'b0; settle_clear();
        pin_in[0] = 1'b1;
        tick(2); rd(2, d); chk("R12 flag not before third edge", d, 0);
        tick(1); rd(2, d); chk("R3 rise sets flag", d, 8'h40);
        wr(2, 8'h40);
        pin_in[0] = 1'b0; tick(4); rd(2, d); chk("R3 fall ignored", d, 0);
    endtask

    task automatic t_fall();
        logic [7:0] d;
        wr(0, 8'h08); pin_in[1] = 1'b0; settle_clear();
        pin_in[1] = 1'b1; tick(4); rd(2, d); chk("R4 rise ignored", d, 0);
        pin_in[1] = 1'b0; tick(3); rd(2, d); chk("R4 fall sets flag", d, 8'h80);
        wr(2, 8'h80); pin_in[1] = 1'b1;
    endtask

    task automatic t_any();
        logic [7:0] d;
        wr(0, 8'h01); pin_in[0] = 1'b1; settle_clear();
        pin_in[0] = 1'b0; tick(3); rd(2, d); chk("R5 fall in change mode", d, 8'h40);
        wr(2, 8'h40);
        pin_in[0] = 1'b1; tick(3); rd(2, d); chk("R5 rise in change mode", d, 8'h40);
        tick(10); rd(2, d); chk("R6 flag holds", d, 8'h40);
        wr(2, 8'h80); rd(2, d); chk("R7 zero write keeps flag", d, 8'h40);
        wr(2, 8'h40); rd(2, d); chk("R7 one write clears", d, 0);
    endtask

    task automatic t_ack_prio();
        logic [7:0] d;
        wr(0, 8'h0F); pin_in = 2'b00; settle_clear();
        wr(1, 8'hC0); gie = 1'b1;
        pin_in = 2'b11; tick(3);
        chk("R11 both requesting", irq_req, 1);
        chk("R11 pin0 wins", irq_vec, 0);
        ack(2'b01);
        chk("R11 pin1 after pin0 acked", irq_vec, 1);
        rd(2, d); chk("R8 ack clears only pin0", d, 8'h80);
        ack(2'b10);
        rd(2, d); chk("R8 ack clears pin1", d, 0);
        chk("R8 req drops", irq_req, 0);
    endtask

    task automatic t_gate();
        logic [7:0] d;
        wr(0, 8'h03); pin_in[0] = 1'b0; settle_clear();
        pin_in[0] = 1'b1; tick(3);
        gie = 1'b0; #1; chk("R10 gie low blocks", irq_req, 0);
        gie = 1'b1; wr(1, 8'h80); chk("R10 enable low blocks", irq_req, 0);
        wr(1, 8'h40); chk("R10 both set passes", irq_req, 1);
        wr(2, 8'h40); wr(1, 8'h00);
    endtask

    task automatic t_level();
        logic [7:0] d;
        wr(0, 8'h00); pin_in[1] = 1'b1; tick(4);
        wr(1, 8'h80); gie = 1'b1;
        pin_in[1] = 1'b0;
        tick(1); chk("R12 level not after one edge", irq_req, 0);
        tick(1); chk("R9 level low requests", irq_req, 1);
        chk("R9 vec pin1", irq_vec, 1);
        rd(2, d); chk("R9 flag zero in level mode", d, 0);
        tick(5); chk("R9 request persists", irq_req, 1);
        pin_in[1] = 1'b1; tick(2); chk("R9 request drops", irq_req, 0);
        wr(1, 8'h00);
    endtask

    task automatic t_pulse();
        logic [7:0] d;
        wr(0, 8'h03); pin_in[0] = 1'b0; settle_clear();
        pin_in[0] = 1'b1; tick(1); pin_in[0] = 1'b0;
        tick(3); rd(2, d); chk("R12 one-cycle pulse caught", d, 8'h40);
        wr(2, 8'h40);
    endtask

    task automatic t_mode_switch();
        logic [7:0] d;
        pin_in[0] = 1'b1; wr(0, 8'h00); tick(4);
        wr(0, 8'h03); tick(3); rd(2, d); chk("R13 level to rise, pin high", d, 0);
        wr(0, 8'h01); tick(3); rd(2, d); chk("R13 rise to change", d, 0);
        pin_in[0] = 1'b0; wr(0, 8'h00); tick(4);
        wr(0, 8'h02); tick(3); rd(2, d); chk("R13 level to fall, pin low", d, 0);
        pin_in[0] = 1'b1; wr(0, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        tick(4);
        t_regs();
        t_rise();
        t_fall();
        t_any();
        t_ack_prio();
        t_gate();
        t_level();
        t_pulse();
        t_mode_switch();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule